// File: doc/BRIEF.md
# Transparent Two-Master Bus Multiplexer

This block lets two bus masters share one local memory bus that was built for a single master. The bus is blocking and single-beat. A master pulses an address strobe for one cycle with its address, write flag, byte enables and write data. It then waits until the bus returns a ready pulse, which comes with read data. Neither master carries any extra signal for the sharing, and neither can tell from its own port that another master exists. The only cost a master sees is that it stalls while it is not selected.

An external select input names the master that should own the bus. Ownership moves at once when no transfer is outstanding. When a transfer is outstanding, ownership moves in the cycle its ready returns. A master that strobes while it is not selected is caught by its own holding stage. That stage keeps the request and the master's ready stays low. When the master is selected again, the held request goes out first, in the same cycle as the switch. A fixed address mask and match value restrict which addresses the block acts on.

Top module: `dual_master_bus_mux`

## Requirements
- R1: After reset, master 0 owns the bus, neither holding stage holds a request, the bus strobe is low and both master ready outputs are low.
- R2: While a transfer is outstanding on the bus (strobe issued, ready not yet returned), a change of the select input does not change ownership. Ownership follows the select input in the cycle the ready returns, or at once when no transfer is outstanding.
- R3: The selected master's strobe, address, write flag, byte enables and write data appear on the bus in the same cycle, including the first cycle after a switch.
- R4: Bus ready and read data go to the master that issued the outstanding transfer, even in a cycle where ownership has already moved to the other master. The other master sees ready low and read data zero.
- R5: An in-range strobe from the unselected master is captured, together with its address, write flag, byte enables and write data, and is not placed on the bus.
- R6: A master whose request is held sees its ready low until its replayed transfer completes.
- R7: In the cycle a master with a held request becomes the owner, the held request is driven on the bus before any new request from that master. A held write keeps its byte enables and write data unchanged.
- R8: A strobe whose address fails the range test ((address AND mask) equal to match) is neither forwarded nor captured and produces no ready.
- R9: A transfer of the selected master gets no extra latency: its ready is seen in the same cycle as the bus ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_m1 | input | 1 | Ownership request: 0 selects master 0, 1 selects master 1 |
| m0_as | input | 1 | Master 0 address strobe |
| m0_addr | input | ADDR_W | Master 0 address |
| m0_we | input | 1 | Master 0 write flag |
| m0_be | input | DATA_W/8 | Master 0 byte enables |
| m0_wdata | input | DATA_W | Master 0 write data |
| m0_rdata | output | DATA_W | Master 0 read data |
| m0_ready | output | 1 | Master 0 transfer complete |
| m1_as | input | 1 | Master 1 address strobe |
| m1_addr | input | ADDR_W | Master 1 address |
| m1_we | input | 1 | Master 1 write flag |
| m1_be | input | DATA_W/8 | Master 1 byte enables |
| m1_wdata | input | DATA_W | Master 1 write data |
| m1_rdata | output | DATA_W | Master 1 read data |
| m1_ready | output | 1 | Master 1 transfer complete |
| mem_as | output | 1 | Bus address strobe |
| mem_addr | output | ADDR_W | Bus address |
| mem_we | output | 1 | Bus write flag |
| mem_be | output | DATA_W/8 | Bus byte enables |
| mem_wdata | output | DATA_W | Bus write data |
| mem_rdata | input | DATA_W | Bus read data |
| mem_ready | input | 1 | Bus transfer complete |

## Verification
The bench builds the block with a 16-bit address, a 32-bit data path, mask 0xFF00 and match 0x1000. The nonzero mask selects the comparing variant of the range test, so an address such as 0x2000 can be shown to be dropped. The bench slave memory can answer after one cycle or after three. The three-cycle setting keeps a transfer outstanding long enough to show a deferred switch, a captured write and the response reaching the old owner in the same cycle as the replay. The one-cycle setting exposes any added latency, and a free-running select toggle gives a long mixed run that a scoreboard checks.

// File: rtl/dmbm_pkg.sv
package dmbm_pkg;
   localparam int unsigned NUM_MASTERS = 2;
   typedef enum logic {
      SRC_M0 = 1'b0,
      SRC_M1 = 1'b1
   } src_e;
endpackage

// File: rtl/dmbm_addr_match.sv
module dmbm_addr_match #(
   parameter int unsigned           ADDR_W = 32,
   parameter logic [ADDR_W-1:0]     MASK   = '0,
   parameter logic [ADDR_W-1:0]     MATCH  = '0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   generate
      if (MASK == '0) begin : g_open
         logic [ADDR_W-1:0] unused_addr;
         assign unused_addr = addr_i;
         assign hit_o = 1'b1;
      end else begin : g_cmp
         assign hit_o = ((addr_i & MASK) == MATCH);
      end
   endgenerate
endmodule

// File: rtl/dmbm_holder.sv
module dmbm_holder #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned BE_W  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              own_i,
   input  logic              as_i,
   input  logic              hit_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic [DATA_W-1:0] wd_i,
   output logic              held_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              we_o,
   output logic [BE_W-1:0]   be_o,
   output logic [DATA_W-1:0] wd_o
);
   logic              held_q;
   logic [ADDR_W-1:0] addr_q;
   logic              we_q;
   logic [BE_W-1:0]   be_q;
   logic [DATA_W-1:0] wd_q;
   logic              take;

   assign take = !held_q && !own_i && as_i && hit_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         addr_q <= '0;
         we_q   <= 1'b0;
         be_q   <= '0;
         wd_q   <= '0;
      end else if (held_q && own_i) begin
         held_q <= 1'b0;
      end else if (take) begin
         held_q <= 1'b1;
         addr_q <= addr_i;
         we_q   <= we_i;
         be_q   <= be_i;
         wd_q   <= wd_i;
      end
   end

   assign held_o = held_q;
   assign addr_o = addr_q;
   assign we_o   = we_q;
   assign be_o   = be_q;
   assign wd_o   = wd_q;

   // R5
   hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_i && as_i && hit_i && !held_q) |=> (held_q && addr_q == $past(addr_i)));

   // R7
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && !own_i) |=> (held_q && $stable(addr_q) && $stable(be_q) && $stable(wd_q) && $stable(we_q)));
endmodule

// File: rtl/dmbm_ctrl.sv
module dmbm_ctrl
   import dmbm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sel_req_i,
   input  logic start_i,
   input  logic bus_ready_i,
   output logic eff_o,
   output logic issuer_o,
   output logic busy_o
);
   src_e owner_q, issuer_q, eff;
   logic busy_q, idle;

   assign idle = !busy_q || bus_ready_i;
   assign eff  = idle ? src_e'(sel_req_i) : owner_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q  <= SRC_M0;
         issuer_q <= SRC_M0;
         busy_q   <= 1'b0;
      end else begin
         owner_q <= eff;
         if (start_i) begin
            busy_q   <= 1'b1;
            issuer_q <= eff;
         end else if (bus_ready_i) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign eff_o    = eff;
   assign issuer_o = issuer_q;
   assign busy_o   = busy_q;

   // R2
   own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !bus_ready_i) |=> $stable(owner_q));

   // R4
   issuer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !bus_ready_i && !start_i) |=> ($stable(issuer_q) && busy_q));
endmodule

// File: rtl/dual_master_bus_mux.sv
module dual_master_bus_mux
   import dmbm_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter logic [ADDR_W-1:0] ADDR_MASK  = '0,
   parameter logic [ADDR_W-1:0] ADDR_MATCH = '0,
   localparam int unsigned      BE_W       = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_m1,
   input  logic              m0_as,
   input  logic [ADDR_W-1:0] m0_addr,
   input  logic              m0_we,
   input  logic [BE_W-1:0]   m0_be,
   input  logic [DATA_W-1:0] m0_wdata,
   output logic [DATA_W-1:0] m0_rdata,
   output logic              m0_ready,
   input  logic              m1_as,
   input  logic [ADDR_W-1:0] m1_addr,
   input  logic              m1_we,
   input  logic [BE_W-1:0]   m1_be,
   input  logic [DATA_W-1:0] m1_wdata,
   output logic [DATA_W-1:0] m1_rdata,
   output logic              m1_ready,
   output logic              mem_as,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [BE_W-1:0]   mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready
);
   localparam int unsigned NM = NUM_MASTERS;

   initial begin
      assert (DATA_W >= 8 && DATA_W % 8 == 0)
         else $error("DATA_W must be a nonzero multiple of 8");
      assert ((ADDR_MATCH & ~ADDR_MASK) == '0)
         else $error("ADDR_MATCH has bits outside ADDR_MASK");
   end

   logic [NM-1:0]     req_as, req_we, req_hit, hold_v, hold_we, rdy_v;
   logic [ADDR_W-1:0] req_addr [NM];
   logic [ADDR_W-1:0] hold_addr[NM];
   logic [BE_W-1:0]   req_be   [NM];
   logic [BE_W-1:0]   hold_be  [NM];
   logic [DATA_W-1:0] req_wd   [NM];
   logic [DATA_W-1:0] hold_wd  [NM];
   logic              eff, issuer, busy;

   assign req_as      = {m1_as, m0_as};
   assign req_we      = {m1_we, m0_we};
   assign req_addr[0] = m0_addr;
   assign req_addr[1] = m1_addr;
   assign req_be[0]   = m0_be;
   assign req_be[1]   = m1_be;
   assign req_wd[0]   = m0_wdata;
   assign req_wd[1]   = m1_wdata;

   dmbm_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_req_i   (sel_m1),
      .start_i     (mem_as),
      .bus_ready_i (mem_ready),
      .eff_o       (eff),
      .issuer_o    (issuer),
      .busy_o      (busy)
   );

   for (genvar k = 0; k < NM; k++) begin : g_port
      dmbm_addr_match #(
         .ADDR_W (ADDR_W),
         .MASK   (ADDR_MASK),
         .MATCH  (ADDR_MATCH)
      ) u_match (
         .addr_i (req_addr[k]),
         .hit_o  (req_hit[k])
      );

      dmbm_holder #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W)
      ) u_hold (
         .clk    (clk),
         .rst_n  (rst_n),
         .own_i  (eff == 1'(k)),
         .as_i   (req_as[k]),
         .hit_i  (req_hit[k]),
         .addr_i (req_addr[k]),
         .we_i   (req_we[k]),
         .be_i   (req_be[k]),
         .wd_i   (req_wd[k]),
         .held_o (hold_v[k]),
         .addr_o (hold_addr[k]),
         .we_o   (hold_we[k]),
         .be_o   (hold_be[k]),
         .wd_o   (hold_wd[k])
      );

      assign rdy_v[k] = busy && mem_ready && (issuer == 1'(k));

      // R6
      stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hold_v[k] |-> !rdy_v[k]);
   end

   always_comb begin
      if (hold_v[eff]) begin
         mem_as    = 1'b1;
         mem_addr  = hold_addr[eff];
         mem_we    = hold_we[eff];
         mem_be    = hold_be[eff];
         mem_wdata = hold_wd[eff];
      end else begin
         mem_as    = req_as[eff] && req_hit[eff];
         mem_addr  = req_addr[eff];
         mem_we    = req_we[eff];
         mem_be    = req_be[eff];
         mem_wdata = req_wd[eff];
      end
   end

   assign m0_ready = rdy_v[0];
   assign m1_ready = rdy_v[1];
   assign m0_rdata = rdy_v[0] ? mem_rdata : '0;
   assign m1_rdata = rdy_v[1] ? mem_rdata : '0;

   // R4
   one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({m1_ready, m0_ready}));

   // R9
   ready_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ready && busy) |-> (m0_ready || m1_ready));
endmodule

// File: tb/test_dual_master_bus_mux.sv
`timescale 1ns/1ps
module test_dual_master_bus_mux;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_m1 = 1'b0;
   logic [1:0]  m_as = '0;
   logic        m_we   [2];
   logic [15:0] m_addr [2];
   logic [3:0]  m_be   [2];
   logic [31:0] m_wd   [2];
   logic [31:0] m0_rdata, m1_rdata, mem_rdata, mem_wdata;
   logic        m0_ready, m1_ready, mem_as, mem_we, mem_ready;
   logic [15:0] mem_addr;
   logic [3:0]  mem_be;

   int checks = 0;
   int errors = 0;
   int iss_n[2];
   int done_n[2];
   logic [32:0] expq0[$];
   logic [32:0] expq1[$];
   logic [31:0] ref_mem[16];
   logic [31:0] slv_mem[16];
   logic [31:0] rd_q;
   logic [3:0]  cnt;
   logic [3:0]  lat = 4'd1;
   bit          fin0, fin1;

   always #4 clk = ~clk;

   dual_master_bus_mux #(
      .ADDR_W(16), .DATA_W(32), .ADDR_MASK(16'hFF00), .ADDR_MATCH(16'h1000)
   ) i_dual_master_bus_mux (
      .clk(clk), .rst_n(rst_n), .sel_m1(sel_m1),
      .m0_as(m_as[0]), .m0_addr(m_addr[0]), .m0_we(m_we[0]), .m0_be(m_be[0]),
      .m0_wdata(m_wd[0]), .m0_rdata(m0_rdata), .m0_ready(m0_ready),
      .m1_as(m_as[1]), .m1_addr(m_addr[1]), .m1_we(m_we[1]), .m1_be(m_be[1]),
      .m1_wdata(m_wd[1]), .m1_rdata(m1_rdata), .m1_ready(m1_ready),
      .mem_as(mem_as), .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   // bench slave memory: answers lat cycles after a strobe
   always @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         rd_q <= '0;
         for (int i = 0; i < 16; i++) slv_mem[i] <= 32'hA500_0000 | i;
      end else if (mem_as) begin
         cnt  <= lat;
         rd_q <= slv_mem[mem_addr[5:2]];
         if (mem_we)
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) slv_mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else if (cnt != 0) begin
         cnt <= cnt - 1'b1;
      end
   end
   assign mem_ready = (cnt == 4'd1);
   assign mem_rdata = mem_ready ? rd_q : '0;

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // driver: drives a strobe and pushes the expected response
   task automatic start(int m, bit we, logic [15:0] a, logic [3:0] be, logic [31:0] wd);
      logic [32:0] item;
      if (we) begin
         for (int b = 0; b < 4; b++)
            if (be[b]) ref_mem[a[5:2]][8*b +: 8] = wd[8*b +: 8];
         item = {1'b0, 32'h0};
      end else begin
         item = {1'b1, ref_mem[a[5:2]]};
      end
      if (m == 0) expq0.push_back(item); else expq1.push_back(item);
      iss_n[m]++;
      m_as[m] = 1'b1; m_we[m] = we; m_addr[m] = a; m_be[m] = be; m_wd[m] = wd;
   endtask

   task automatic stop(int m);
      m_as[m] = 1'b0;
   endtask

   task automatic access(int m, bit we, logic [15:0] a, logic [3:0] be, logic [31:0] wd);
      @(negedge clk);
      start(m, we, a, be, wd);
      @(negedge clk);
      stop(m);
      while (done_n[m] < iss_n[m]) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (expq0.size() != 0 || expq1.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // monitor: pops the scoreboard on every ready a master sees
   always @(negedge clk) begin
      logic [32:0] e;
      if (rst_n) begin
         if (m0_ready) begin
            checks++;
            if (expq0.size() == 0) begin
               errors++;
               $display("FAIL R4 master 0 unexpected ready: actual=1 expected=0");
            end else begin
               e = expq0.pop_front();
               if (e[32] && m0_rdata != e[31:0]) begin
                  errors++;
                  $display("FAIL R4 master 0 rdata: actual=%h expected=%h", m0_rdata, e[31:0]);
               end
            end
            done_n[0]++;
         end
         if (m1_ready) begin
            checks++;
            if (expq1.size() == 0) begin
               errors++;
               $display("FAIL R4 master 1 unexpected ready: actual=1 expected=0");
            end else begin
               e = expq1.pop_front();
               if (e[32] && m1_rdata != e[31:0]) begin
                  errors++;
                  $display("FAIL R4 master 1 rdata: actual=%h expected=%h", m1_rdata, e[31:0]);
               end
            end
            done_n[1]++;
         end
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      for (int k = 0; k < 2; k++) begin
         m_we[k] = 1'b0; m_addr[k] = '0; m_be[k] = '0; m_wd[k] = '0;
      end
      for (int i = 0; i < 16; i++) ref_mem[i] = 32'hA500_0000 | i;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(!mem_as && !m0_ready && !m1_ready, "R1", "outputs after reset",
          {29'd0, mem_as, m1_ready, m0_ready}, 32'd0);

      // R3/R9 master 0 owns after reset, write forwarded in the same cycle
      @(negedge clk);
      start(0, 1'b1, 16'h1000, 4'hF, 32'hCAFE_0001);
      #1 chk(mem_as && mem_addr == 16'h1000 && mem_we && mem_wdata == 32'hCAFE_0001,
             "R3", "m0 write on bus", {16'd0, mem_addr}, 32'h1000);
      @(negedge clk);
      stop(0);
      #1 chk(m0_ready, "R9", "ready one cycle after strobe", {31'd0, m0_ready}, 32'd1);
      chk(!m1_ready && m1_rdata == 0, "R4", "other master quiet", m1_rdata, 32'd0);
      access(0, 1'b1, 16'h1004, 4'b0011, 32'h1111_BEEF);
      access(0, 1'b0, 16'h1004, 4'hF, 32'h0);

      // R3 immediate switch when idle
      wait_idle();
      @(negedge clk);
      sel_m1 = 1'b1;
      start(1, 1'b0, 16'h1020, 4'hF, 32'h0);
      #1 chk(mem_as && mem_addr == 16'h1020, "R3", "switch at once when idle",
             {16'd0, mem_addr}, 32'h1020);
      @(negedge clk);
      stop(1);
      #1 chk(m1_ready, "R9", "new owner ready without delay", {31'd0, m1_ready}, 32'd1);

      // R2/R4/R5/R6/R7 deferred switch and write replay with slow slave
      wait_idle();
      lat = 4'd3;
      sel_m1 = 1'b0;
      @(negedge clk);
      start(0, 1'b0, 16'h1004, 4'hF, 32'h0);
      @(negedge clk);
      stop(0);
      sel_m1 = 1'b1;
      start(1, 1'b1, 16'h1024, 4'b0101, 32'h1234_5678);
      #1 chk(!mem_as, "R2", "no switch while transfer outstanding", {31'd0, mem_as}, 32'd0);
      @(negedge clk);
      stop(1);
      #1 chk(!mem_as && !m1_ready, "R6", "held master stalled",
             {30'd0, mem_as, m1_ready}, 32'd0);
      @(negedge clk);
      #1 chk(m0_ready, "R4", "response stays with old owner", {31'd0, m0_ready}, 32'd1);
      chk(!m1_ready, "R6", "held master ready low", {31'd0, m1_ready}, 32'd0);
      chk(mem_as && mem_addr == 16'h1024 && mem_we, "R7", "held write replayed at switch",
          {16'd0, mem_addr}, 32'h1024);
      chk(mem_be == 4'b0101, "R7", "replay byte enables", {28'd0, mem_be}, 32'h5);
      chk(mem_wdata == 32'h1234_5678, "R7", "replay write data", mem_wdata, 32'h1234_5678);
      chk(m1_ready == 1'b0, "R5", "captured write not completed early", {31'd0, m1_ready}, 32'd0);
      wait_idle();
      lat = 4'd1;
      access(1, 1'b0, 16'h1024, 4'hF, 32'h0);

      // R7 held read goes first on reselection
      wait_idle();
      @(negedge clk);
      start(0, 1'b0, 16'h1008, 4'hF, 32'h0);
      #1 chk(!mem_as, "R5", "unselected strobe kept off bus", {31'd0, mem_as}, 32'd0);
      @(negedge clk);
      stop(0);
      sel_m1 = 1'b0;
      #1 chk(mem_as && mem_addr == 16'h1008 && !mem_we, "R7", "held read issued on reselection",
             {16'd0, mem_addr}, 32'h1008);
      wait_idle();

      // R8 out-of-range addresses ignored, selected and unselected
      @(negedge clk);
      m_as[0] = 1'b1; m_addr[0] = 16'h2000; m_we[0] = 1'b0;
      #1 chk(!mem_as, "R8", "out-of-range strobe dropped", {31'd0, mem_as}, 32'd0);
      @(negedge clk);
      m_as[0] = 1'b0;
      repeat (3) begin
         @(negedge clk);
         #1 chk(!m0_ready && !mem_as, "R8", "no ready for dropped strobe",
                {30'd0, mem_as, m0_ready}, 32'd0);
      end
      @(negedge clk);
      m_as[1] = 1'b1; m_addr[1] = 16'h2004; m_we[1] = 1'b0;
      @(negedge clk);
      m_as[1] = 1'b0;
      sel_m1 = 1'b1;
      #1 chk(!mem_as, "R8", "out-of-range strobe not captured", {31'd0, mem_as}, 32'd0);
      access(1, 1'b0, 16'h1028, 4'hF, 32'h0);

      // mixed run with free-running select
      wait_idle();
      fork
         begin
            for (int i = 0; i < 12; i++)
               access(0, (i % 3) == 0, 16'h1000 + 16'((i % 8) * 4),
                      (i % 4 == 1) ? 4'b0110 : 4'hF, 32'h0A00_0000 + i);
            fin0 = 1'b1;
         end
         begin
            for (int i = 0; i < 12; i++)
               access(1, (i % 3) == 1, 16'h1020 + 16'((i % 8) * 4),
                      (i % 4 == 2) ? 4'b1001 : 4'hF, 32'h0B00_0000 + i);
            fin1 = 1'b1;
         end
         begin
            int n = 0;
            while (!(fin0 && fin1)) begin
               repeat (2 + (n % 3)) @(negedge clk);
               sel_m1 = ~sel_m1;
               n++;
            end
         end
      join
      repeat (4) @(negedge clk);
      chk(expq0.size() == 0 && expq1.size() == 0, "R4", "all responses delivered",
          expq0.size() + expq1.size(), 32'd0);
      finish_run();
   end
endmodule